// File: doc/BRIEF.md
# Receive Descriptor DMA Writer

This block sits between a receive MAC and system memory. Incoming frames arrive as a byte stream that carries an end marker and a CRC-error flag. The block walks a linked list of four-word receive descriptors. Each descriptor holds a status-and-length word, a buffer start address, a reserved word and a pointer to the next descriptor. The block claims a descriptor only when the owner field shows the controller. It then packs the frame bytes into 32-bit words and writes them into that descriptor's buffer over a single word-wide memory port. After the frame it writes back the length and status, returns the descriptor to the CPU and follows the next pointer.

Software sets the list start address and turns reception on. From then on the block runs by itself. The CPU hands descriptors back by rewriting their owner field. A poll strobe is needed only to wake the block after it has stalled on a CPU-owned descriptor with no frame arriving. One-cycle event pulses report frame start, frame completion, good frames, oversize frames and a missing descriptor. An interrupt controller outside the block consumes these pulses.

Top module: `rx_desc_dma`

## Requirements
- R1: The block fetches descriptor word 0 and uses the descriptor only when bits 31:30 equal 2'b10. For any other owner value it pulses `ev_unavail`, leaves the descriptor and its buffer unwritten, and keeps `cur_desc_addr` pointing at it.
- R2: Frame byte n is stored in the byte lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)) of the word at the buffer start address plus 4*(n/4). In the final, partial word the unused upper lanes are written as zero, and no word past it is written.
- R3: On completion, status word 0 is written with bits 31:30 = 2'b00 (CPU owned) and bit 16 (receive interrupt) = 1. Bits 15:0 hold the stored byte count, CRC bytes included. Bit 20 (good) is 1 when the frame is not flagged bad.
- R4: A frame whose last byte carries `in_crc_err` is stored and returned with bit 17 set and bit 20 clear.
- R5: A frame longer than MAX_FRAME bytes (default 1518) sets status bit 19. With `cfg_long_ok` = 1 all of its bytes are stored, the length counts all of them, and bit 20 is still set if there is no CRC error.
- R6: With `cfg_long_ok` = 0, only the first MAX_FRAME bytes of an oversize frame are stored and the rest are discarded. The length field reads MAX_FRAME, bit 19 is set and bit 20 is clear.
- R7: The buffer address comes from descriptor word 1 and appears on `cur_buf_addr`. After write-back `cur_desc_addr` takes the value of word 3. Word 2 is never written.
- R8: `ev_early` pulses once, on the first byte of a frame that has a descriptor. `ev_intr` pulses once per completed frame, `ev_good` with it when bit 20 is written, and `ev_toolong` when bit 19 is written.
- R9: With no descriptor, `in_ready` stays high and bytes are dropped up to and including the end marker, with no memory write. The descriptor is then fetched again.
- R10: In the stalled state with no frame in progress, a `poll_kick` pulse makes the block fetch the current descriptor again. Reception otherwise needs no poll.
- R11: While `cfg_rx_en` is low and no frame is in progress, `in_ready` and `mem_req` are low and `cur_desc_addr` follows `cfg_ring_base`. Reset leaves `in_ready`, `mem_req` and all events low.
- R12: `in_ready` is low while a descriptor is being fetched or written back, so the stream is held and never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | ADDR_W | Address of the first descriptor |
| cfg_rx_en | input | 1 | Reception enable |
| cfg_long_ok | input | 1 | Store oversize frames in full |
| poll_kick | input | 1 | Re-fetch strobe for the stalled state |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_err | input | 1 | Frame failed CRC, valid with in_last |
| in_ready | output | 1 | Stream byte accepted this cycle when valid |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| cur_desc_addr | output | ADDR_W | Current descriptor address |
| cur_buf_addr | output | ADDR_W | Buffer start of the current descriptor |
| ev_early | output | 1 | First byte of a frame stored |
| ev_good | output | 1 | Good frame completed |
| ev_intr | output | 1 | Frame completed |
| ev_toolong | output | 1 | Oversize frame completed |
| ev_unavail | output | 1 | Fetched descriptor is CPU owned |

## Verification
The bench targets the following corner cases. Each is listed with the symptom a faulty design would show.

- **Partial last word.** Frames whose length is not a multiple of four are sent. A packer that drops the tail word would lose bytes. One that skips zero-filling would leave stale lanes. One that writes one word too many would overwrite the sentinel that follows the buffer.
- **Missing descriptor.** The list runs into a CPU-owned descriptor while a frame is still arriving. A faulty design would stall the stream, or it would spill the dropped bytes into the buffer or status of that descriptor.
- **Handing a descriptor back.** After the stall the CPU returns the descriptor and strobes the poll input. If the block fails to fetch again, the next frame would be lost.
- **Oversize frames.** A 1604-byte frame is sent once with long frames allowed and once without. A wrong length limit, a missing too-long bit, or a good bit set on a truncated frame would each appear in the status word or in the sentinel past byte 1518.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    localparam int LEN_W     = 16;
    localparam int WORD_W    = 32;
    localparam int OWN_HI    = 31;
    localparam int OWN_LO    = 30;
    localparam int BIT_GOOD  = 20;
    localparam int BIT_LONG  = 19;
    localparam int BIT_CRC   = 17;
    localparam int BIT_INTR  = 16;

    localparam logic [1:0] OWN_DMA = 2'b10;
    localparam logic [1:0] OWN_CPU = 2'b00;

    // byte offsets of the descriptor words
    localparam int OFF_BUF  = 4;
    localparam int OFF_NEXT = 12;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_RD_OWN,
        ST_GET_OWN,
        ST_RD_BUF,
        ST_GET_BUF,
        ST_RD_NXT,
        ST_GET_NXT,
        ST_RECV,
        ST_FLUSH,
        ST_WBACK,
        ST_NODESC
    } rxdw_state_e;

    typedef struct packed {
        logic early;
        logic good;
        logic intr;
        logic toolong;
        logic unavail;
    } rxdw_evt_t;

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] lane,
                                                   input logic [7:0] b);
        return w | (WORD_W'(b) << {lane, 3'b000});
    endfunction

    function automatic logic [WORD_W-1:0] make_status(input logic [LEN_W-1:0] len,
                                                      input logic good,
                                                      input logic toolong,
                                                      input logic crc);
        logic [WORD_W-1:0] s;
        s = '0;
        s[OWN_HI:OWN_LO] = OWN_CPU;
        s[BIT_GOOD]      = good;
        s[BIT_LONG]      = toolong;
        s[BIT_CRC]       = crc;
        s[BIT_INTR]      = 1'b1;
        s[LEN_W-1:0]     = len;
        return s;
    endfunction

endpackage

// File: rtl/rxdw_packer.sv
module rxdw_packer
    import rxdw_pkg::*;
#(
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc,
    input  logic [7:0]        byte_in,
    input  logic              last,
    input  logic              long_ok,
    output logic              pend,
    output logic [LEN_W-1:0]  pend_off,
    output logic [WORD_W-1:0] pend_data,
    output logic [LEN_W-1:0]  stored_len,
    output logic              too_long
);
    localparam logic [LEN_W-1:0] LIMIT   = LEN_W'(MAX_FRAME);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [1:0]        lane;
    logic [WORD_W-1:0] word_q;
    logic [LEN_W-1:0]  cnt_all;
    logic [LEN_W-1:0]  cnt_st;
    logic              keep;
    logic [WORD_W-1:0] merged;
    logic [LEN_W-1:0]  floor_off;

    assign keep      = (long_ok && cnt_st != LEN_MAX) || (cnt_st < LIMIT);
    assign merged    = put_byte(word_q, lane, byte_in);
    assign floor_off = {cnt_st[LEN_W-1:2], 2'b00};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane    <= '0;
            word_q  <= '0;
            cnt_all <= '0;
            cnt_st  <= '0;
            pend    <= 1'b0;
            if (rst) begin
                pend_off  <= '0;
                pend_data <= '0;
            end
        end else begin
            pend <= 1'b0;
            if (acc) begin
                if (cnt_all != LEN_MAX)
                    cnt_all <= cnt_all + 1'b1;
                if (keep) begin
                    cnt_st <= cnt_st + 1'b1;
                    if (lane == 2'd3 || last) begin
                        pend      <= 1'b1;
                        pend_data <= merged;
                        pend_off  <= floor_off;
                        word_q    <= '0;
                        lane      <= '0;
                    end else begin
                        word_q <= merged;
                        lane   <= lane + 1'b1;
                    end
                end else if (last && lane != 2'd0) begin
                    pend      <= 1'b1;
                    pend_data <= word_q;
                    pend_off  <= floor_off;
                    word_q    <= '0;
                    lane      <= '0;
                end
            end
        end
    end

    assign stored_len = cnt_st;
    assign too_long   = cnt_all > LIMIT;

endmodule

// File: rtl/rxdw_seq.sv
module rxdw_seq
    import rxdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic              cfg_rx_en,
    input  logic              cfg_long_ok,
    input  logic              poll_kick,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_crc_err,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              pk_pend,
    input  logic [LEN_W-1:0]  pk_off,
    input  logic [WORD_W-1:0] pk_data,
    input  logic [LEN_W-1:0]  pk_len,
    input  logic              pk_long,
    output logic              pk_clr,
    output logic              pk_acc,
    output logic [ADDR_W-1:0] cur_desc,
    output logic [ADDR_W-1:0] cur_buf,
    output rxdw_evt_t         evt,
    output rxdw_state_e       state
);
    logic [ADDR_W-1:0] nxt_desc;
    logic              in_frame;
    logic              drop_mid;
    logic              crc_q;
    logic              good_w;
    logic              take;

    assign good_w = !crc_q && (!pk_long || cfg_long_ok);

    always_comb begin
        case (state)
            ST_RECV:   in_ready = cfg_rx_en || in_frame;
            ST_NODESC: in_ready = cfg_rx_en || drop_mid;
            default:   in_ready = 1'b0;
        endcase
    end

    assign take   = in_valid && in_ready;
    assign pk_acc = take && (state == ST_RECV);
    assign pk_clr = (state == ST_GET_NXT);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = '0;
        if (pk_pend) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_buf + ADDR_W'(pk_off);
            mem_wdata = pk_data;
        end else begin
            case (state)
                ST_RD_OWN: mem_req = 1'b1;
                ST_RD_BUF: begin
                    mem_req  = 1'b1;
                    mem_addr = cur_desc + ADDR_W'(OFF_BUF);
                end
                ST_RD_NXT: begin
                    mem_req  = 1'b1;
                    mem_addr = cur_desc + ADDR_W'(OFF_NEXT);
                end
                ST_WBACK: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = make_status(pk_len, good_w, pk_long, crc_q);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OFF;
            cur_desc <= '0;
            cur_buf  <= '0;
            nxt_desc <= '0;
            in_frame <= 1'b0;
            drop_mid <= 1'b0;
            crc_q    <= 1'b0;
            evt      <= '0;
        end else begin
            evt <= '0;
            case (state)
                ST_OFF: begin
                    cur_desc <= cfg_ring_base;
                    if (cfg_rx_en) state <= ST_RD_OWN;
                end
                ST_RD_OWN:  state <= ST_GET_OWN;
                ST_GET_OWN: begin
                    if (mem_rdata[OWN_HI:OWN_LO] == OWN_DMA) begin
                        state <= ST_RD_BUF;
                    end else begin
                        evt.unavail <= 1'b1;
                        drop_mid    <= 1'b0;
                        state       <= ST_NODESC;
                    end
                end
                ST_RD_BUF:  state <= ST_GET_BUF;
                ST_GET_BUF: begin
                    cur_buf <= mem_rdata;
                    state   <= ST_RD_NXT;
                end
                ST_RD_NXT:  state <= ST_GET_NXT;
                ST_GET_NXT: begin
                    nxt_desc <= mem_rdata;
                    in_frame <= 1'b0;
                    state    <= ST_RECV;
                end
                ST_RECV: begin
                    if (take) begin
                        if (!in_frame) evt.early <= 1'b1;
                        in_frame <= 1'b1;
                        if (in_last) begin
                            crc_q <= in_crc_err;
                            state <= ST_FLUSH;
                        end
                    end else if (!cfg_rx_en && !in_frame) begin
                        state <= ST_OFF;
                    end
                end
                ST_FLUSH: state <= ST_WBACK;
                ST_WBACK: begin
                    evt.intr    <= 1'b1;
                    evt.good    <= good_w;
                    evt.toolong <= pk_long;
                    cur_desc    <= nxt_desc;
                    in_frame    <= 1'b0;
                    state       <= cfg_rx_en ? ST_RD_OWN : ST_OFF;
                end
                ST_NODESC: begin
                    if (take) begin
                        drop_mid <= !in_last;
                        if (in_last) state <= ST_RD_OWN;
                    end else if (!drop_mid) begin
                        if (!cfg_rx_en)     state <= ST_OFF;
                        else if (poll_kick) state <= ST_RD_OWN;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rxdw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic              cfg_rx_en,
    input  logic              cfg_long_ok,
    input  logic              poll_kick,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_crc_err,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_desc_addr,
    output logic [ADDR_W-1:0] cur_buf_addr,
    output logic              ev_early,
    output logic              ev_good,
    output logic              ev_intr,
    output logic              ev_toolong,
    output logic              ev_unavail
);
    logic              pk_pend;
    logic [LEN_W-1:0]  pk_off;
    logic [WORD_W-1:0] pk_data;
    logic [LEN_W-1:0]  pk_len;
    logic              pk_long;
    logic              pk_clr;
    logic              pk_acc;
    rxdw_evt_t         evt;
    rxdw_state_e       st_w;

    rxdw_packer #(.MAX_FRAME(MAX_FRAME)) u_packer (
        .clk        (clk),
        .rst        (rst),
        .clr        (pk_clr),
        .acc        (pk_acc),
        .byte_in    (in_data),
        .last       (in_last),
        .long_ok    (cfg_long_ok),
        .pend       (pk_pend),
        .pend_off   (pk_off),
        .pend_data  (pk_data),
        .stored_len (pk_len),
        .too_long   (pk_long)
    );

    rxdw_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .cfg_ring_base (cfg_ring_base),
        .cfg_rx_en     (cfg_rx_en),
        .cfg_long_ok   (cfg_long_ok),
        .poll_kick     (poll_kick),
        .in_valid      (in_valid),
        .in_last       (in_last),
        .in_crc_err    (in_crc_err),
        .in_ready      (in_ready),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .pk_pend       (pk_pend),
        .pk_off        (pk_off),
        .pk_data       (pk_data),
        .pk_len        (pk_len),
        .pk_long       (pk_long),
        .pk_clr        (pk_clr),
        .pk_acc        (pk_acc),
        .cur_desc      (cur_desc_addr),
        .cur_buf       (cur_buf_addr),
        .evt           (evt),
        .state         (st_w)
    );

    assign ev_early   = evt.early;
    assign ev_good    = evt.good;
    assign ev_intr    = evt.intr;
    assign ev_toolong = evt.toolong;
    assign ev_unavail = evt.unavail;

endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk
    import rxdw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 1518
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_long_ok,
    input logic              in_valid,
    input logic              in_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [ADDR_W-1:0] cur_desc_addr,
    input logic              ev_early,
    input logic              ev_intr,
    input logic              ev_unavail,
    input rxdw_state_e       state
);
    logic status_wr;
    assign status_wr = mem_req && mem_we && (mem_addr == cur_desc_addr);

    p_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_owner_clear_r3: assert property (@(posedge clk) disable iff (rst)
        status_wr |-> (mem_wdata[31:30] == 2'b00 && mem_wdata[16]));

    p_len_cap_r6: assert property (@(posedge clk) disable iff (rst)
        (status_wr && !cfg_long_ok) |-> (mem_wdata[15:0] <= 16'(MAX_FRAME)));

    p_intr_after_wb_r8: assert property (@(posedge clk) disable iff (rst)
        ev_intr |-> ($past(state) == ST_WBACK));

    p_early_on_byte_r8: assert property (@(posedge clk) disable iff (rst)
        ev_early |-> $past(in_valid && in_ready));

    p_drop_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NODESC) |-> !mem_req);

    p_unavail_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ev_unavail |-> !(mem_req && mem_we));

    p_off_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF) |-> (!in_ready && !mem_req));

    p_fetch_stall_r12: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RECV && state != ST_NODESC) |-> !in_ready);

endmodule

bind rx_desc_dma rx_desc_dma_chk #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_long_ok   (cfg_long_ok),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .cur_desc_addr (cur_desc_addr),
    .ev_early      (ev_early),
    .ev_intr       (ev_intr),
    .ev_unavail    (ev_unavail),
    .state         (st_w)
);

// File: tb/rx_desc_dma_bench.sv
module rx_desc_dma_bench;

    localparam int MAXF  = 1518;
    localparam int WORDS = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_ring_base = '0;
    logic        cfg_rx_en = 1'b0;
    logic        cfg_long_ok = 1'b0;
    logic        poll_kick = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_crc_err = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [31:0] cur_desc_addr, cur_buf_addr;
    logic        ev_early, ev_good, ev_intr, ev_toolong, ev_unavail;

    always #5 clk = ~clk;

    rx_desc_dma u_rx_desc_dma (
        .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_rx_en(cfg_rx_en),
        .cfg_long_ok(cfg_long_ok), .poll_kick(poll_kick), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_crc_err(in_crc_err),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_desc_addr(cur_desc_addr),
        .cur_buf_addr(cur_buf_addr), .ev_early(ev_early), .ev_good(ev_good),
        .ev_intr(ev_intr), .ev_toolong(ev_toolong), .ev_unavail(ev_unavail)
    );

    // memory model with a bench-side write path
    logic [31:0] mem [0:WORDS-1];
    logic        tb_fill = 1'b0;
    logic        tb_we = 1'b0;
    logic [31:0] tb_a = '0, tb_d = '0;

    function automatic logic [31:0] sentinel(input int i);
        return 32'h3C00_0000 | 32'(i);
    endfunction

    always @(posedge clk) begin
        if (tb_fill) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= sentinel(i);
        end else if (tb_we) begin
            mem[tb_a[12:2]] <= tb_d;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[12:2]];
        end
    end

    int n_early = 0, n_good = 0, n_intr = 0, n_long = 0, n_unav = 0;
    always @(posedge clk) begin
        if (!rst) begin
            if (ev_early)   n_early++;
            if (ev_good)    n_good++;
            if (ev_intr)    n_intr++;
            if (ev_toolong) n_long++;
            if (ev_unavail) n_unav++;
        end
    end

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int id, input int n);
        return 8'(n * 7 + id * 29 + 3);
    endfunction

    task automatic wmem(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic setup_ring(input logic [31:0] base, input int nt, input int nown,
                              input logic [31:0] bufb, input logic [31:0] stride);
        for (int i = 0; i < nt; i++) begin
            logic [31:0] d;
            d = base + 32'(16 * i);
            wmem(d, (i < nown) ? 32'h8000_0000 : 32'h0000_1234);
            wmem(d + 4, bufb + 32'(i) * stride);
            wmem(d + 8, 32'h5EED_0000 | {16'h0, d[15:0]});
            wmem(d + 12, d + 16);
        end
    endtask

    task automatic restart(input logic [31:0] base);
        cfg_ring_base = base;
        repeat (2) @(negedge clk);
        chk("R11 desc follows base", cur_desc_addr, base);
        chk("R11 ready low when off", {31'b0, in_ready}, 32'd0);
        cfg_rx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12 ready low during fetch", {31'b0, in_ready}, 32'd0);
        repeat (8) @(negedge clk);
    endtask

    task automatic send_frame(input int id, input int len, input bit crc);
        for (int n = 0; n < len; n++) begin
            if ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid   = 1'b1;
            in_data    = exp_byte(id, n);
            in_last    = (n == len - 1);
            in_crc_err = crc && (n == len - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_crc_err = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input logic [31:0] d, input logic [31:0] b,
                               input int id, input int len, input bit crc, input bit lok);
        int stored, nw, bad;
        bit too, good;
        logic [31:0] st, w;
        too    = len > MAXF;
        stored = (too && !lok) ? MAXF : len;
        good   = !crc && (!too || lok);
        st     = {2'b00, 9'b0, good, too, 1'b0, crc, 1'b1, 16'(stored)};
        chk({tag, " R3 status word"}, mem[d[12:2]], st);
        nw  = (stored + 3) / 4;
        bad = 0;
        for (int k = 0; k < nw; k++) begin
            for (int j = 0; j < 4; j++)
                w[8*j +: 8] = (4 * k + j < stored) ? exp_byte(id, 4 * k + j) : 8'h00;
            if (mem[b[12:2] + k] !== w) bad++;
        end
        chk({tag, " R2 buffer bytes"}, 32'(bad), 32'd0);
        chk({tag, " R2 no overrun"}, mem[b[12:2] + nw], sentinel(int'(b[12:2]) + nw));
        chk({tag, " R7 reserved untouched"}, mem[d[12:2] + 2], 32'h5EED_0000 | {16'h0, d[15:0]});
    endtask

    int exp_good;

    initial begin
        void'($urandom(32'd24601));
        repeat (4) @(negedge clk);
        chk("R11 reset ready", {31'b0, in_ready}, 32'd0);
        chk("R11 reset mem_req", {31'b0, mem_req}, 32'd0);
        chk("R11 reset events", {27'b0, ev_early, ev_good, ev_intr, ev_toolong, ev_unavail}, 32'd0);
        rst = 1'b0;
        tb_fill = 1'b1;
        @(negedge clk);
        tb_fill = 1'b0;

        // Phase A: short frames, ring exhaustion, drop, hand back
        setup_ring(32'h000, 4, 2, 32'h100, 32'h100);
        restart(32'h000);
        send_frame(1, 64, 1'b0);
        check_frame("A1", 32'h000, 32'h100, 1, 64, 1'b0, 1'b0);
        chk("R8 early after first frame", 32'(n_early), 32'd1);
        send_frame(2, 17, 1'b0);
        check_frame("A2 partial word", 32'h010, 32'h200, 2, 17, 1'b0, 1'b0);
        chk("R7 desc follows next pointer", cur_desc_addr, 32'h020);
        chk("R7 buffer address from word1", cur_buf_addr, 32'h200);
        chk("R1 unavailable event", 32'(n_unav), 32'd1);
        chk("R1 cpu-owned desc untouched", mem[32'h020 >> 2], 32'h0000_1234);
        send_frame(3, 20, 1'b0);
        chk("R9 dropped frame no status", mem[32'h020 >> 2], 32'h0000_1234);
        chk("R9 dropped frame no data", mem[32'h300 >> 2], sentinel(32'h300 >> 2));
        chk("R9 no early on drop", 32'(n_early), 32'd2);
        chk("R9 refetch after drop", 32'(n_unav), 32'd2);
        wmem(32'h020, 32'h8000_0000);
        @(negedge clk);
        poll_kick = 1'b1;
        @(negedge clk);
        poll_kick = 1'b0;
        repeat (8) @(negedge clk);
        send_frame(4, 9, 1'b1);
        check_frame("R10 kicked R4 crc", 32'h020, 32'h300, 4, 9, 1'b1, 1'b0);
        chk("R4 crc frame not good", 32'(n_good), 32'd2);
        chk("R8 intr per frame", 32'(n_intr), 32'd3);

        // Phase B: oversize frames
        cfg_rx_en = 1'b0;
        repeat (3) @(negedge clk);
        setup_ring(32'h040, 3, 2, 32'h800, 32'h800);
        cfg_long_ok = 1'b1;
        restart(32'h040);
        send_frame(5, 1604, 1'b0);
        check_frame("R5 long kept", 32'h040, 32'h800, 5, 1604, 1'b0, 1'b1);
        cfg_long_ok = 1'b0;
        send_frame(6, 1604, 1'b0);
        check_frame("R6 long cut", 32'h050, 32'h1000, 6, 1604, 1'b0, 1'b0);
        chk("R8 toolong events", 32'(n_long), 32'd2);
        chk("R5 R6 good count", 32'(n_good), 32'd3);

        // Phase C: random lengths, gaps and CRC errors
        cfg_rx_en = 1'b0;
        repeat (3) @(negedge clk);
        setup_ring(32'h080, 6, 5, 32'h1800, 32'h100);
        restart(32'h080);
        exp_good = 3;
        for (int r = 0; r < 5; r++) begin
            int len;
            bit crc;
            len = 1 + int'($urandom % 200);
            crc = ($urandom % 6) == 0;
            if (!crc) exp_good++;
            send_frame(10 + r, len, crc);
            check_frame($sformatf("C%0d len%0d", r, len), 32'h080 + 32'(16 * r),
                        32'h1800 + 32'(r) * 32'h100, 10 + r, len, crc, 1'b0);
        end
        chk("R8 total early", 32'(n_early), 32'd10);
        chk("R8 total intr", 32'(n_intr), 32'd10);
        chk("R8 total good", 32'(n_good), 32'(exp_good));
        chk("R7 ring end", cur_desc_addr, 32'h0D0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule